// File: doc/BRIEF.md
# PCIe Root-Port Event Interrupt Controller

This block gathers the error and status events of a PCIe root-port bridge into one level-sensitive interrupt. Each event source delivers a one-cycle pulse. The block holds that pulse in a sticky 32-bit status word, and software clears it by writing ones. A separate enable word, where 1 means enabled, selects which held events drive the interrupt output. The output is a registered, active-high level. It stays high as long as any enabled event is still pending.

The four legacy INTx wires are handled differently. They are level inputs and are never latched. Each wire passes through a synchronizer and appears live in its own pending field, which has a matching enable field. The OR of the enabled, pending wires is fed into one position of the main event word as a live level. The block also reports a synchronized link-up flag and holds a bridge-enable control bit, which it drives out to the bridge datapath. Software reaches every field through a plain 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `pcie_evt_irq_ctrl`

## Requirements
- R1: After reset, the status word, the event enable word, the INTx enable field and the bridge-enable bit all read 0, and `irq_o` and `bridge_en_o` are low.
- R2: A pulse on `evt_pulse_i[n]` sets status bit n at offset 0xE10 on that clock edge, for any latched position n. The latched positions are 0, 3, 4, 8–12, 15, 17 and 20–28. A set bit stays set after the pulse ends.
- R3: A write to 0xE10 clears each latched status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit remains set.
- R5: The positions 1, 2, 5–7, 13, 14, 18 and 29–31 always read 0 in the status word and in the enable word at 0xE14, whatever pulses or writes arrive. An unmapped address reads 0.
- R6: `irq_o` is the OR over all bits of (status AND enable at 0xE14), registered once. It rises one cycle after the status bit or enable bit that causes it, and falls one cycle after the cause goes away.
- R7: Bits 19:16 of 0xE38 show the live wires `intx_i[3:0]` after SYNC_STAGES clock edges. These bits are not latched: they drop when the wire drops.
- R8: Status bit 16 reads 1 exactly when some synchronized INTx wire is high and its enable bit is 1. The INTx enable field is bits 19:16 of 0xE3C. Pulses on `evt_pulse_i[16]` and write-one-to-clear on bit 16 have no effect on status bit 16.
- R9: Bit 11 of 0xE1C shows `link_up_i` after SYNC_STAGES clock edges. All other bits of 0xE1C read 0.
- R10: Bit 0 of 0xE20 is the bridge-enable bit. It can be written and read back, and it drives `bridge_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse_i | input | 32 | One-cycle event pulses, one per status position |
| intx_i | input | 4 | Legacy INTx A–D level wires, asynchronous |
| link_up_i | input | 1 | Link-up level from the PHY, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt, active high |
| bridge_en_o | output | 1 | Bridge enable control |

## Verification
The hardest case to reach is the collision: an event pulse and a write-one-to-clear hitting the same status bit in the same cycle. The bench sets up this case by driving the pulse and the write strobe on the same falling edge, so the next rising edge sees both. It then reads the bit back. A second subtle case is INTx bit 16, which can look sticky when it is not. To cover it, the bench enables a wire, tries to clear bit 16 and to pulse it, then releases the wire and checks that the bit falls only after the synchronizer delay.

// File: rtl/pcie_evt_pkg.sv
package pcie_evt_pkg;

    localparam int DW = 32;
    localparam int AW = 12;
    localparam int NUM_INTX = 4;

    localparam logic [AW-1:0] OFS_STATUS  = 12'hE10;
    localparam logic [AW-1:0] OFS_ENABLE  = 12'hE14;
    localparam logic [AW-1:0] OFS_PHY     = 12'hE1C;
    localparam logic [AW-1:0] OFS_RPCTL   = 12'hE20;
    localparam logic [AW-1:0] OFS_INTX    = 12'hE38;
    localparam logic [AW-1:0] OFS_INTX_EN = 12'hE3C;

    localparam int BIT_INTX_SUM = 16;
    localparam int INTX_LSB     = 16;
    localparam int BIT_LINKUP   = 11;
    localparam int BIT_BRIDGE   = 0;

    // latched event positions (pulse-driven, sticky)
    localparam logic [DW-1:0] LATCH_MASK = 32'h1FF2_9F19;
    // every position that can ever read 1 in status/enable
    localparam logic [DW-1:0] VALID_MASK = LATCH_MASK | (32'h1 << BIT_INTX_SUM);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE,
        SEL_PHY,
        SEL_RPCTL,
        SEL_INTX,
        SEL_INTX_EN
    } reg_sel_e;

    typedef struct packed {
        logic          wr;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } reg_wreq_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_STATUS:  s = SEL_STATUS;
            OFS_ENABLE:  s = SEL_ENABLE;
            OFS_PHY:     s = SEL_PHY;
            OFS_RPCTL:   s = SEL_RPCTL;
            OFS_INTX:    s = SEL_INTX;
            OFS_INTX_EN: s = SEL_INTX_EN;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pcie_evt_sync.sv
module pcie_evt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcie_evt_status.sv
module pcie_evt_status #(
    parameter int            W    = 32,
    parameter logic [W-1:0]  MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    // new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= ((stat_q & ~clr_i) | evt_i) & MASK;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/pcie_evt_regs.sv
module pcie_evt_regs
    import pcie_evt_pkg::*;
#(
    parameter int              NI    = NUM_INTX,
    parameter logic [DW-1:0]   VALID = VALID_MASK
) (
    input  logic          clk,
    input  logic          rst,
    input  reg_wreq_t     wreq_i,
    output logic [DW-1:0] en_o,
    output logic [NI-1:0] intx_en_o,
    output logic          ben_o
);
    logic [DW-1:0] en_q;
    logic [NI-1:0] intx_en_q;
    logic          ben_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            intx_en_q <= '0;
            ben_q     <= 1'b0;
        end else if (wreq_i.wr) begin
            case (wreq_i.sel)
                SEL_ENABLE:  en_q      <= wreq_i.data & VALID;
                SEL_INTX_EN: intx_en_q <= wreq_i.data[INTX_LSB +: NI];
                SEL_RPCTL:   ben_q     <= wreq_i.data[BIT_BRIDGE];
                default: ;
            endcase
        end
    end

    assign en_o      = en_q;
    assign intx_en_o = intx_en_q;
    assign ben_o     = ben_q;
endmodule

// File: rtl/pcie_evt_irq_ctrl.sv
module pcie_evt_irq_ctrl
    import pcie_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DW-1:0]       evt_pulse_i,
    input  logic [NUM_INTX-1:0] intx_i,
    input  logic                link_up_i,
    input  logic                reg_wr_i,
    input  logic [AW-1:0]       reg_addr_i,
    input  logic [DW-1:0]       reg_wdata_i,
    output logic [DW-1:0]       reg_rdata_o,
    output logic                irq_o,
    output logic                bridge_en_o
);
    localparam int SYNC_W = NUM_INTX + 1;

    reg_sel_e          rsel;
    reg_wreq_t         wreq;
    logic [SYNC_W-1:0] sync_q;
    logic [NUM_INTX-1:0] intx_live;
    logic              link_live;
    logic [DW-1:0]     stat_q;
    logic [DW-1:0]     stat_view;
    logic [DW-1:0]     clr_vec;
    logic [DW-1:0]     en_q;
    logic [NUM_INTX-1:0] intx_en_q;
    logic              ben_q;
    logic              intx_hit;
    logic              irq_q;

    assign rsel      = decode_addr(reg_addr_i);
    assign wreq.wr   = reg_wr_i;
    assign wreq.sel  = rsel;
    assign wreq.data = reg_wdata_i;

    pcie_evt_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({link_up_i, intx_i}),
        .q_o (sync_q)
    );
    assign intx_live = sync_q[NUM_INTX-1:0];
    assign link_live = sync_q[NUM_INTX];

    assign clr_vec = (reg_wr_i && rsel == SEL_STATUS) ? reg_wdata_i : '0;

    pcie_evt_status #(.W(DW), .MASK(LATCH_MASK)) u_status (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_pulse_i),
        .clr_i  (clr_vec),
        .stat_o (stat_q)
    );

    pcie_evt_regs #(.NI(NUM_INTX), .VALID(VALID_MASK)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wreq_i    (wreq),
        .en_o      (en_q),
        .intx_en_o (intx_en_q),
        .ben_o     (ben_q)
    );

    assign intx_hit  = |(intx_live & intx_en_q);
    assign stat_view = stat_q | (DW'(intx_hit) << BIT_INTX_SUM);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(stat_view & en_q);
    end

    always_comb begin
        case (rsel)
            SEL_STATUS:  reg_rdata_o = stat_view;
            SEL_ENABLE:  reg_rdata_o = en_q;
            SEL_PHY:     reg_rdata_o = DW'(link_live) << BIT_LINKUP;
            SEL_RPCTL:   reg_rdata_o = DW'(ben_q) << BIT_BRIDGE;
            SEL_INTX:    reg_rdata_o = DW'(intx_live) << INTX_LSB;
            SEL_INTX_EN: reg_rdata_o = DW'(intx_en_q) << INTX_LSB;
            default:     reg_rdata_o = '0;
        endcase
    end

    assign irq_o       = irq_q;
    assign bridge_en_o = ben_q;
endmodule

// File: rtl/pcie_evt_irq_chk.sv
module pcie_evt_irq_chk
    import pcie_evt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [DW-1:0]       evt_pulse_i,
    input logic                reg_wr_i,
    input logic [AW-1:0]       reg_addr_i,
    input logic [DW-1:0]       reg_wdata_i,
    input logic [DW-1:0]       reg_rdata_o,
    input logic                irq_o,
    input logic                bridge_en_o,
    input logic [DW-1:0]       stat_q,
    input logic [DW-1:0]       en_q,
    input logic [NUM_INTX-1:0] intx_en_q
);
    logic [DW-1:0] w1c_vec;
    logic [DW-1:0] new_evt;
    assign w1c_vec = (reg_wr_i && reg_addr_i == OFS_STATUS) ? reg_wdata_i : '0;
    assign new_evt = evt_pulse_i & LATCH_MASK;

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q) & ~$past(w1c_vec) & ~stat_q) == '0)); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|new_evt) |=> ((stat_q & $past(new_evt)) == $past(new_evt))); // R4

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == OFS_STATUS || reg_addr_i == OFS_ENABLE)
        |-> ((reg_rdata_o & ~VALID_MASK) == '0)); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |=> !irq_o); // R6

    AST_INTX_GATED: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == OFS_STATUS && intx_en_q == '0) |-> !reg_rdata_o[BIT_INTX_SUM]); // R8

    AST_BRIDGE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_i && reg_addr_i == OFS_RPCTL) |=> (bridge_en_o == $past(reg_wdata_i[BIT_BRIDGE]))); // R10
endmodule

bind pcie_evt_irq_ctrl pcie_evt_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_pulse_i (evt_pulse_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .bridge_en_o (bridge_en_o),
    .stat_q      (stat_q),
    .en_q        (en_q),
    .intx_en_q   (intx_en_q)
);

// File: tb/test_pcie_evt_irq_ctrl.sv
module test_pcie_evt_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_pulse_i = '0;
    logic [3:0]  intx_i = '0;
    logic        link_up_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [11:0] reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic        bridge_en_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_evt_irq_ctrl i_pcie_evt_irq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt_pulse_i (evt_pulse_i),
        .intx_i      (intx_i),
        .link_up_i   (link_up_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o),
        .bridge_en_o (bridge_en_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_pulse_i = v;
        @(negedge clk);
        evt_pulse_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        reg_read(12'hE10, r); check("R1 status", r, 32'h0);
        reg_read(12'hE14, r); check("R1 enable", r, 32'h0);
        reg_read(12'hE3C, r); check("R1 intx enable", r, 32'h0);
        reg_read(12'hE20, r); check("R1 bridge bit", r, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 bridge_en", {31'b0, bridge_en_o}, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] r;
        pulse(32'h1000_0001);
        reg_read(12'hE10, r); check("R2 latch 0 and 28", r, 32'h1000_0001);
        pulse(32'h0000_0200);
        repeat (2) @(negedge clk);
        reg_read(12'hE10, r); check("R2 sticky", r, 32'h1000_0201);
    endtask

    task automatic t_w1c();
        logic [31:0] r;
        reg_write(12'hE10, 32'h0000_0001);
        reg_read(12'hE10, r); check("R3 clear bit 0", r, 32'h1000_0200);
        reg_write(12'hE10, 32'h0);
        reg_read(12'hE10, r); check("R3 zero write keeps", r, 32'h1000_0200);
        reg_write(12'hE10, 32'hFFFF_FFFF);
        reg_read(12'hE10, r); check("R3 clear all", r, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] r;
        @(negedge clk);
        evt_pulse_i = 32'h0000_0800;
        reg_wr_i = 1'b1; reg_addr_i = 12'hE10; reg_wdata_i = 32'h0000_0800;
        @(negedge clk);
        evt_pulse_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        reg_read(12'hE10, r); check("R4 event beats clear", r, 32'h0000_0800);
        reg_write(12'hE10, 32'h0000_0800);
        reg_read(12'hE10, r); check("R4 later clear", r, 32'h0);
    endtask

    task automatic t_unused();
        logic [31:0] r;
        pulse(32'hE004_60E6);
        reg_read(12'hE10, r); check("R5 unused status", r, 32'h0);
        reg_write(12'hE14, 32'hFFFF_FFFF);
        reg_read(12'hE14, r); check("R5 enable valid only", r, 32'h1FF3_9F19);
        reg_write(12'hE00, 32'hFFFF_FFFF);
        reg_read(12'hE00, r); check("R5 unmapped", r, 32'h0);
        reg_write(12'hE14, 32'h0);
    endtask

    task automatic t_irq();
        reg_write(12'hE14, 32'h0000_0008);
        check("R6 idle low", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        evt_pulse_i = 32'h0000_0008;
        @(negedge clk);
        evt_pulse_i = '0;
        check("R6 one cycle later", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R6 raised", {31'b0, irq_o}, 32'h1);
        reg_write(12'hE14, 32'h0);
        check("R6 not yet dropped", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R6 masked", {31'b0, irq_o}, 32'h0);
        reg_write(12'hE10, 32'h0000_0008);
    endtask

    task automatic t_intx();
        logic [31:0] r;
        @(negedge clk);
        intx_i = 4'b0100;
        @(negedge clk);
        reg_read(12'hE38, r); check("R7 sync delay", r, 32'h0);
        @(negedge clk);
        reg_read(12'hE38, r); check("R7 live wire", r, 32'h0004_0000);
        reg_read(12'hE10, r); check("R8 not enabled", r, 32'h0);
        reg_write(12'hE3C, 32'h0004_0000);
        reg_read(12'hE3C, r); check("R8 enable field", r, 32'h0004_0000);
        reg_read(12'hE10, r); check("R8 summary bit", r, 32'h0001_0000);
        reg_write(12'hE10, 32'h0001_0000);
        reg_read(12'hE10, r); check("R8 clear ignored", r, 32'h0001_0000);
        reg_write(12'hE14, 32'h0001_0000);
        @(negedge clk);
        check("R6 intx irq", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        intx_i = 4'b0000;
        repeat (2) @(negedge clk);
        reg_read(12'hE38, r); check("R7 not latched", r, 32'h0);
        reg_read(12'hE10, r); check("R8 summary drops", r, 32'h0);
        pulse(32'h0001_0000);
        reg_read(12'hE10, r); check("R8 pulse ignored", r, 32'h0);
        reg_write(12'hE14, 32'h0);
        reg_write(12'hE3C, 32'h0);
    endtask

    task automatic t_link();
        logic [31:0] r;
        @(negedge clk);
        link_up_i = 1'b1;
        repeat (2) @(negedge clk);
        reg_read(12'hE1C, r); check("R9 link up", r, 32'h0000_0800);
        link_up_i = 1'b0;
        repeat (2) @(negedge clk);
        reg_read(12'hE1C, r); check("R9 link down", r, 32'h0);
    endtask

    task automatic t_bridge();
        logic [31:0] r;
        reg_write(12'hE20, 32'hFFFF_FFFF);
        reg_read(12'hE20, r); check("R10 readback", r, 32'h1);
        check("R10 output on", {31'b0, bridge_en_o}, 32'h1);
        reg_write(12'hE20, 32'h0);
        check("R10 output off", {31'b0, bridge_en_o}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch();
        t_w1c();
        t_collide();
        t_unused();
        t_irq();
        t_intx();
        t_link();
        t_bridge();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule